// File: doc/BRIEF.md
# Card Host Interrupt Status Registers

This block keeps the two interrupt status words of a memory-card host controller together with one mask word for each. Event strobes from the command, data and card-detect logic set latched bits, which software clears by writing zero to them. Three bits show live levels (card present, DAT0 line level, command busy) and take no notice of writes. The read-buffer-ready and write-buffer-ready bits are set only on the rising edge of their buffer condition. A level still held after a clear does not set them again.

A single interrupt output is the OR of every readable status bit whose mask bit is 0. Software reaches the four words through a simple word-wide port: a write strobe, an address, write data, and read data that follows the address combinationally. The status words sit at byte offsets 0x038 and 0x03C. The mask words sit right after them at 0x040 and 0x044.

Top module: `card_host_irq_regs`

## Requirements
- R1: After reset the latched bits of both status words are 0, both mask words read 0xFFFFFFFF, and irq is low.
- R2: Status word 1 (offset 0x038) latches a one-cycle strobe in the following positions: response done at bit 0, data done at bit 2, card removed at bit 3, card inserted at bit 4. The bit reads 1 from the cycle after the strobe.
- R3: Status word 2 (offset 0x03C) latches these error strobes: bit 0 index, bit 1 CRC, bit 2 end bit, bit 3 data timeout, bit 4 illegal write, bit 5 illegal read, bit 6 response timeout, bit 15 illegal access.
- R4: Word 1 bit 5 shows card_present, word 2 bit 7 shows dat0_level and word 2 bit 14 shows cmd_busy, in the same cycle. Writes to these bits have no effect.
- R5: Word 2 bit 8 is set on a rising edge of rbuf_full. After it is cleared while rbuf_full stays high, it stays 0 until rbuf_full falls and rises again.
- R6: Word 2 bit 9 behaves the same way for wbuf_empty.
- R7: Writing a status word clears each latched bit whose write-data bit is 0. Latched bits whose write-data bit is 1 keep their value.
- R8: A set strobe in the same cycle as a clearing write wins, and the bit reads 1 afterwards.
- R9: The mask words at 0x040 and 0x044 read back the value written. irq is high exactly when some readable bit of a status word is 1 and the matching mask bit is 0.
- R10: Unassigned bit positions of the status words read 0. Other addresses read 0, and writes to them change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 11 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| ev_resp_done | input | 1 | Response complete strobe |
| ev_data_done | input | 1 | Data transfer complete strobe |
| ev_card_out | input | 1 | Card removed strobe |
| ev_card_in | input | 1 | Card inserted strobe |
| card_present | input | 1 | Live card-detect level |
| ev_err_index | input | 1 | Command index error strobe |
| ev_err_crc | input | 1 | CRC error strobe |
| ev_err_endbit | input | 1 | End bit error strobe |
| ev_err_timeout | input | 1 | Data timeout strobe |
| ev_err_wr_illegal | input | 1 | Illegal write strobe |
| ev_err_rd_illegal | input | 1 | Illegal read strobe |
| ev_err_resp_timeout | input | 1 | Response timeout strobe |
| ev_err_access | input | 1 | Illegal access strobe |
| dat0_level | input | 1 | Live DAT0 line level |
| cmd_busy | input | 1 | Live command busy level |
| rbuf_full | input | 1 | Read buffer full condition |
| wbuf_empty | input | 1 | Write buffer empty condition |
| irq | output | 1 | Interrupt request |

## Verification
Each event strobe is fired on its own, in turn, and the whole status word is read back. This separates a wrong bit position from a bit that also sets its neighbours. For each event the bench also unmasks only that bit and checks that irq follows the mask. All eight combinations of the three live levels are swept, including writes of zero while they are high, to tell pass-through apart from latching. Each buffer condition is held high across a clear and then toggled, which separates edge capture from level capture. Clears with mixed ones and zeros and a strobe that lands on the same cycle as a clear test the write priority.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
    localparam int STATUS_W = 32;

    // status word 1 positions
    localparam int W1_RESP    = 0;
    localparam int W1_DATA    = 2;
    localparam int W1_OUT     = 3;
    localparam int W1_IN      = 4;
    localparam int W1_PRESENT = 5;

    // status word 2 positions
    localparam int W2_INDEX   = 0;
    localparam int W2_CRC     = 1;
    localparam int W2_ENDBIT  = 2;
    localparam int W2_TIMEOUT = 3;
    localparam int W2_ILL_WR  = 4;
    localparam int W2_ILL_RD  = 5;
    localparam int W2_RSP_TO  = 6;
    localparam int W2_DAT0    = 7;
    localparam int W2_RBUF    = 8;
    localparam int W2_WBUF    = 9;
    localparam int W2_BUSY    = 14;
    localparam int W2_ACCESS  = 15;

    localparam logic [STATUS_W-1:0] W1_LATCH = STATUS_W'((1 << W1_RESP) | (1 << W1_DATA) |
                                                         (1 << W1_OUT) | (1 << W1_IN));
    localparam logic [STATUS_W-1:0] W2_LATCH = STATUS_W'((1 << W2_INDEX) | (1 << W2_CRC) |
                                                         (1 << W2_ENDBIT) | (1 << W2_TIMEOUT) |
                                                         (1 << W2_ILL_WR) | (1 << W2_ILL_RD) |
                                                         (1 << W2_RSP_TO) | (1 << W2_RBUF) |
                                                         (1 << W2_WBUF) | (1 << W2_ACCESS));

    typedef struct packed {
        logic [STATUS_W-1:0] m1;
        logic [STATUS_W-1:0] m2;
    } mask_regs_t;
endpackage

// File: rtl/card_irq_edge_rise.sv
module card_irq_edge_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = level[i] & ~st_q.prev[i];
    end
endmodule

// File: rtl/card_irq_latch_word.sv
module card_irq_latch_word #(
    parameter int               W          = 32,
    parameter logic [W-1:0]     LATCH_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] bits
);
    typedef struct packed {
        logic [W-1:0] flags;
    } latch_state_t;

    latch_state_t st_d, st_q;
    logic [W-1:0] kept;

    always_comb begin
        st_d = st_q;
        // a zero in the write data drops the bit, a one keeps it
        kept = clr_wr ? (st_q.flags & clr_data) : st_q.flags;
        // a set in the same cycle overrides the clear
        st_d.flags = (kept | set_ev) & LATCH_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits = st_q.flags;
endmodule

// File: rtl/card_host_irq_regs.sv
module card_host_irq_regs
    import card_irq_pkg::*;
#(
    parameter int                ADDR_W    = 11,
    parameter logic [ADDR_W-1:0] STS1_OFS  = 'h038,
    parameter logic [ADDR_W-1:0] STS2_OFS  = 'h03C,
    parameter logic [ADDR_W-1:0] MASK1_OFS = 'h040,
    parameter logic [ADDR_W-1:0] MASK2_OFS = 'h044
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [STATUS_W-1:0] wdata,
    output logic [STATUS_W-1:0] rdata,
    input  logic                ev_resp_done,
    input  logic                ev_data_done,
    input  logic                ev_card_out,
    input  logic                ev_card_in,
    input  logic                card_present,
    input  logic                ev_err_index,
    input  logic                ev_err_crc,
    input  logic                ev_err_endbit,
    input  logic                ev_err_timeout,
    input  logic                ev_err_wr_illegal,
    input  logic                ev_err_rd_illegal,
    input  logic                ev_err_resp_timeout,
    input  logic                ev_err_access,
    input  logic                dat0_level,
    input  logic                cmd_busy,
    input  logic                rbuf_full,
    input  logic                wbuf_empty,
    output logic                irq
);
    localparam int DW     = STATUS_W;
    localparam int N_EDGE = 2;

    logic [DW-1:0]     set1, set2, lat1, lat2, live1, live2, view1, view2;
    logic [N_EDGE-1:0] buf_lvl, buf_rise;
    logic              wr_sts1, wr_sts2;
    logic [DW-1:0]     mask1_q, mask2_q;
    mask_regs_t        mask_d, mask_q;

    assign buf_lvl = {wbuf_empty, rbuf_full};
    assign wr_sts1 = wr_en && (addr == STS1_OFS);
    assign wr_sts2 = wr_en && (addr == STS2_OFS);

    card_irq_edge_rise #(.N(N_EDGE)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (buf_lvl),
        .rise  (buf_rise)
    );

    always_comb begin
        set1            = '0;
        set1[W1_RESP]   = ev_resp_done;
        set1[W1_DATA]   = ev_data_done;
        set1[W1_OUT]    = ev_card_out;
        set1[W1_IN]     = ev_card_in;

        set2            = '0;
        set2[W2_INDEX]  = ev_err_index;
        set2[W2_CRC]    = ev_err_crc;
        set2[W2_ENDBIT] = ev_err_endbit;
        set2[W2_TIMEOUT]= ev_err_timeout;
        set2[W2_ILL_WR] = ev_err_wr_illegal;
        set2[W2_ILL_RD] = ev_err_rd_illegal;
        set2[W2_RSP_TO] = ev_err_resp_timeout;
        set2[W2_RBUF]   = buf_rise[0];
        set2[W2_WBUF]   = buf_rise[1];
        set2[W2_ACCESS] = ev_err_access;

        live1             = '0;
        live1[W1_PRESENT] = card_present;
        live2             = '0;
        live2[W2_DAT0]    = dat0_level;
        live2[W2_BUSY]    = cmd_busy;
    end

    card_irq_latch_word #(.W(DW), .LATCH_MASK(W1_LATCH)) u_word1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set1),
        .clr_wr   (wr_sts1),
        .clr_data (wdata),
        .bits     (lat1)
    );

    card_irq_latch_word #(.W(DW), .LATCH_MASK(W2_LATCH)) u_word2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set2),
        .clr_wr   (wr_sts2),
        .clr_data (wdata),
        .bits     (lat2)
    );

    assign view1 = lat1 | live1;
    assign view2 = lat2 | live2;

    // mask registers
    always_comb begin
        mask_d = mask_q;
        if (wr_en && (addr == MASK1_OFS)) mask_d.m1 = wdata;
        if (wr_en && (addr == MASK2_OFS)) mask_d.m2 = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '{m1: '1, m2: '1};
        else        mask_q <= mask_d;
    end

    assign mask1_q = mask_q.m1;
    assign mask2_q = mask_q.m2;

    // read mux
    always_comb begin
        if (addr == STS1_OFS)       rdata = view1;
        else if (addr == STS2_OFS)  rdata = view2;
        else if (addr == MASK1_OFS) rdata = mask_q.m1;
        else if (addr == MASK2_OFS) rdata = mask_q.m2;
        else                        rdata = '0;
    end

    assign irq = (|(view1 & ~mask_q.m1)) | (|(view2 & ~mask_q.m2));
endmodule

// File: rtl/card_host_irq_regs_chk.sv
module card_host_irq_regs_chk #(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] STS1_OFS = 'h038,
    parameter logic [ADDR_W-1:0] STS2_OFS = 'h03C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              irq,
    input logic              dat0_level,
    input logic              rbuf_full,
    input logic [31:0]       set1,
    input logic [31:0]       set2,
    input logic [31:0]       lat1,
    input logic [31:0]       lat2,
    input logic [31:0]       mask1_q,
    input logic [31:0]       mask2_q
);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set1 != 32'h0) |=> ((lat1 & $past(set1)) == $past(set1)));

    assert_zero_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == STS1_OFS && wdata == 32'h0 && set1 == 32'h0) |=> (lat1 == 32'h0));

    assert_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == STS2_OFS && wdata == 32'hFFFF_FFFF && set2 == 32'h0) |=> (lat2 == $past(lat2)));

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask1_q == 32'hFFFF_FFFF && mask2_q == 32'hFFFF_FFFF) |-> !irq);

    assert_dat0_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == STS2_OFS) |-> (rdata[7] == dat0_level));

    assert_rbuf_from_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat2[8]) |-> $past(rbuf_full));
endmodule

bind card_host_irq_regs card_host_irq_regs_chk #(
    .ADDR_W   (ADDR_W),
    .STS1_OFS (STS1_OFS),
    .STS2_OFS (STS2_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .irq        (irq),
    .dat0_level (dat0_level),
    .rbuf_full  (rbuf_full),
    .set1       (set1),
    .set2       (set2),
    .lat1       (lat1),
    .lat2       (lat2),
    .mask1_q    (mask1_q),
    .mask2_q    (mask2_q)
);

// File: tb/card_host_irq_regs_bench.sv
`timescale 1ns/1ps
module card_host_irq_regs_bench;
    localparam logic [10:0] A_S1 = 11'h038;
    localparam logic [10:0] A_S2 = 11'h03C;
    localparam logic [10:0] A_M1 = 11'h040;
    localparam logic [10:0] A_M2 = 11'h044;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  ev1 = '0;
    logic [7:0]  ev2 = '0;
    logic        card_present = 1'b0, dat0_level = 1'b0, cmd_busy = 1'b0;
    logic [1:0]  bufc = '0;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    int pos1 [4] = '{0, 2, 3, 4};
    int pos2 [8] = '{0, 1, 2, 3, 4, 5, 6, 15};

    always #2.5 clk = ~clk;

    card_host_irq_regs u_card_host_irq_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ev_resp_done(ev1[0]), .ev_data_done(ev1[1]), .ev_card_out(ev1[2]), .ev_card_in(ev1[3]),
        .card_present(card_present),
        .ev_err_index(ev2[0]), .ev_err_crc(ev2[1]), .ev_err_endbit(ev2[2]),
        .ev_err_timeout(ev2[3]), .ev_err_wr_illegal(ev2[4]), .ev_err_rd_illegal(ev2[5]),
        .ev_err_resp_timeout(ev2[6]), .ev_err_access(ev2[7]),
        .dat0_level(dat0_level), .cmd_busy(cmd_busy),
        .rbuf_full(bufc[0]), .wbuf_empty(bufc[1]), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [10:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m1, input logic [7:0] m2);
        @(negedge clk);
        ev1 = m1; ev2 = m2;
        @(negedge clk);
        ev1 = '0; ev2 = '0;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_S1, v); chk(v, 32'h0, "R1 word1 after reset");
        rd(A_S2, v); chk(v, 32'h0, "R1 word2 after reset");
        rd(A_M1, v); chk(v, 32'hFFFF_FFFF, "R1 mask1 after reset");
        rd(A_M2, v); chk(v, 32'hFFFF_FFFF, "R1 mask2 after reset");
        chk({31'h0, irq}, 32'h0, "R1 irq after reset");

        // R2 word1 events, one at a time
        for (int i = 0; i < 4; i++) begin
            e = 32'h1 << pos1[i];
            pulse(4'(1 << i), 8'h0);
            rd(A_S1, v); chk(v, e, "R2 word1 event position");
            chk({31'h0, irq}, 32'h0, "R9 masked event keeps irq low");
            wr(A_M1, ~e);
            #1 chk({31'h0, irq}, 32'h1, "R9 unmasked word1 event raises irq");
            wr(A_M1, 32'hFFFF_FFFF);
            wr(A_S1, ~e);
            rd(A_S1, v); chk(v, 32'h0, "R7 zero at event bit clears it");
        end

        // R3 word2 error events
        for (int j = 0; j < 8; j++) begin
            e = 32'h1 << pos2[j];
            pulse(4'h0, 8'(1 << j));
            rd(A_S2, v); chk(v, e, "R3 word2 error position");
            wr(A_M2, ~e);
            #1 chk({31'h0, irq}, 32'h1, "R9 unmasked word2 event raises irq");
            wr(A_M2, 32'hFFFF_FFFF);
            #1 chk({31'h0, irq}, 32'h0, "R9 remasked word2 event");
            wr(A_S2, 32'h0);
            rd(A_S2, v); chk(v, 32'h0, "R7 word2 cleared by zero");
        end

        // R7 ones keep, mixed clear
        pulse(4'b0011, 8'h0);
        wr(A_S1, 32'hFFFF_FFFF);
        rd(A_S1, v); chk(v, 32'h5, "R7 write of ones keeps bits");
        wr(A_S1, 32'hFFFF_FFFE);
        rd(A_S1, v); chk(v, 32'h4, "R7 mixed write clears only zero bits");
        wr(A_S1, 32'h0);

        // R8 set and clear in the same cycle
        @(negedge clk);
        ev2 = 8'h02; wr_en = 1'b1; addr = A_S2; wdata = 32'h0;
        @(negedge clk);
        ev2 = 8'h0; wr_en = 1'b0;
        rd(A_S2, v); chk(v, 32'h2, "R8 set wins over clear");
        wr(A_S2, 32'h0);

        // R4 live levels, all combinations
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            card_present = k[0]; dat0_level = k[1]; cmd_busy = k[2];
            rd(A_S1, v); chk(v, 32'(k & 1) << 5, "R4 card present live");
            rd(A_S2, v); chk(v, (32'((k >> 1) & 1) << 7) | (32'((k >> 2) & 1) << 14),
                             "R4 dat0 and busy live");
        end
        wr(A_S1, 32'h0); wr(A_S2, 32'h0);
        rd(A_S1, v); chk(v, 32'h20, "R4 write ignored on card present");
        rd(A_S2, v); chk(v, 32'h4080, "R4 write ignored on dat0 and busy");

        // R9 live bit drives irq through mask
        wr(A_M1, ~32'h20);
        #1 chk({31'h0, irq}, 32'h1, "R9 live bit unmasked raises irq");
        @(negedge clk); card_present = 1'b0; dat0_level = 1'b0; cmd_busy = 1'b0;
        #1 chk({31'h0, irq}, 32'h0, "R9 live bit low drops irq");
        wr(A_M2, 32'h1234_5678);
        rd(A_M2, v); chk(v, 32'h1234_5678, "R9 mask2 readback");
        wr(A_M1, 32'hFFFF_FFFF); wr(A_M2, 32'hFFFF_FFFF);

        // R5 / R6 buffer edge capture
        for (int b = 0; b < 2; b++) begin
            e = 32'h100 << b;
            @(negedge clk); bufc[b] = 1'b1;
            @(negedge clk);
            rd(A_S2, v); chk(v, e, b == 0 ? "R5 rise sets read ready" : "R6 rise sets write ready");
            wr(A_S2, 32'h0);
            repeat (3) @(negedge clk);
            rd(A_S2, v); chk(v, 32'h0, b == 0 ? "R5 held level does not reset bit" : "R6 held level does not reset bit");
            bufc[b] = 1'b0;
            @(negedge clk);
            rd(A_S2, v); chk(v, 32'h0, b == 0 ? "R5 fall sets nothing" : "R6 fall sets nothing");
            bufc[b] = 1'b1;
            @(negedge clk);
            rd(A_S2, v); chk(v, e, b == 0 ? "R5 second rise sets again" : "R6 second rise sets again");
            bufc[b] = 1'b0;
            wr(A_S2, 32'h0);
        end

        // R10 unused bits and other addresses
        @(negedge clk); bufc = 2'b11; ev1 = 4'hF; ev2 = 8'hFF;
        @(negedge clk); bufc = 2'b00; ev1 = 4'h0; ev2 = 8'h0;
        rd(A_S1, v); chk(v, 32'h1D, "R10 word1 only assigned bits");
        rd(A_S2, v); chk(v, 32'h837F, "R10 word2 only assigned bits");
        wr(11'h048, 32'h0);
        rd(A_S1, v); chk(v, 32'h1D, "R10 write elsewhere leaves word1");
        rd(A_S2, v); chk(v, 32'h837F, "R10 write elsewhere leaves word2");
        rd(11'h000, v); chk(v, 32'h0, "R10 other address reads zero");

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog R1 actual hung expected done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule